// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the device-side control logic of a serial flash that takes status-register commands over a four-wire SPI slave port. It decodes four one-byte instructions: set the write enable latch, clear it, read the status byte, and write the status byte. It holds the write enable latch, three block-protect bits and a status-lock bit, and it honours a hardware write-protect pin. The protect bits are only stored and reported.

An accepted status write does not commit instantly. Raising chip select starts a self-timed cycle, which a clock counter stands in for here. For the whole cycle a busy flag is visible in the status byte, and at its end the write enable latch clears. All SPI pins are brought into the system clock domain through synchronisers. The serial clock is therefore expected to run several times slower than the system clock.

Top module: `spi_flash_sr`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output is high impedance.
- R2: Opcode 0x06 sets the write enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly 8 bits; any other bit count leaves the latch unchanged.
- R3: Opcode 0x05 returns the status byte MSB first in SPI mode 0 (driven on the falling edge, sampled on the rising edge). The byte repeats for as long as chip select stays low. The output is high impedance whenever chip select is high.
- R4: Opcode 0x01 followed by one data byte changes the status byte only if the write enable latch is already 1.
- R5: A status write is discarded unless chip select rises after exactly 16 bits.
- R6: An accepted write loads data bits 7 and 4..2 into status bits 7 and 4..2. Status bits 6 and 5 always read 0, and data bits 1 and 0 have no effect.
- R7: Status bit 0 (busy) reads 1 for TW_CYCLES system clocks from the chip-select rise that starts a write, then reads 0. The status byte stays readable throughout.
- R8: When the busy cycle ends, the write enable latch reads 0.
- R9: When status bit 7 is 1 and the write-protect input is low, status writes are ignored. With the pin high they are accepted.
- R10: While busy is 1, every instruction other than 0x05 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Hardware write protect, active low |
| miso | output | 1 | Serial data out of the device, high impedance when idle |

## Verification
The assertions rely on the SPI pins changing slowly relative to the system clock. Each serial-clock phase and each chip-select level must last longer than the synchroniser depth plus one edge-detect cycle. Data must be stable at each rising edge, and the write-protect pin must not move within a frame. The bench drives every pin from the falling system-clock edge and holds each serial half-period for eight system clocks. It changes the write-protect pin only between frames and leaves several idle clocks after each chip-select rise. Read-back checks during a busy cycle are spaced well away from its boundary.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  // status bits that a write may change: lock (7) and protect (4..2)
  localparam logic [7:0] WR_MASK    = 8'h9C;
endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= RST_VAL;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_idle,
  input  logic             sck_rise,
  input  logic             mosi_s,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [7:0]       data_byte,
  output logic             op_done
);
  logic [7:0] sh;
  logic [7:0] nxt;
  assign nxt = {sh[6:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      bit_cnt   <= '0;
      sh        <= '0;
      opcode    <= '0;
      data_byte <= '0;
      op_done   <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (sck_rise) begin
        sh <= nxt;
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(7)) begin
          opcode  <= nxt;
          op_done <= 1'b1;
        end
        if (bit_cnt == CNT_W'(15)) data_byte <= nxt;
      end
    end
  end
endmodule

// File: rtl/sfsr_tx.sv
module sfsr_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_idle,
  input  logic       start,
  input  logic       sck_fall,
  input  logic [7:0] status,
  output logic       rd_active,
  output logic       miso_q
);
  logic [7:0] sh;
  logic [2:0] idx;

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      rd_active <= 1'b0;
      idx       <= '0;
      sh        <= '0;
      miso_q    <= 1'b0;
    end else if (start) begin
      rd_active <= 1'b1;
      idx       <= '0;
    end else if (sck_fall && rd_active) begin
      if (idx == 3'd0) begin
        miso_q <= status[7];
        sh     <= {status[6:0], 1'b0};
      end else begin
        miso_q <= sh[7];
        sh     <= {sh[6:0], 1'b0};
      end
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sfsr_busy.sv
module sfsr_busy #(
  parameter int TW_CYCLES = 1000,
  localparam int TW_W = $clog2(TW_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [TW_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= TW_W'(TW_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/spi_flash_sr.sv
module spi_flash_sr #(
  parameter int TW_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = 5,
  localparam int TW_W  = $clog2(TW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  import sfsr_pkg::*;

  logic cs_s, sck_s, mosi_s, wp_s;
  logic cs_d, sck_d;
  logic cs_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] opcode, data_byte, prot_q, status;
  logic op_done, wel, wip, busy_done, wr_start, locked, rd_start;
  logic rd_active, miso_q;
  logic [TW_W-1:0] busy_cnt;

  sfsr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, mosi, wp_n}),
    .q({cs_s, sck_s, mosi_s, wp_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_d;
  assign sck_rise = ~cs_s & sck_s & ~sck_d;
  assign sck_fall = ~cs_s & ~sck_s & sck_d;

  sfsr_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst(rst), .cs_idle(cs_s), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .bit_cnt(bit_cnt), .opcode(opcode),
    .data_byte(data_byte), .op_done(op_done)
  );

  assign locked   = prot_q[7] & ~wp_s;
  assign wr_start = cs_rise && !wip && wel && !locked &&
                    (bit_cnt == CNT_W'(16)) && (opcode == OP_WR_STAT);

  sfsr_busy #(.TW_CYCLES(TW_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(wr_start),
    .busy(wip), .done(busy_done), .cnt(busy_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel    <= 1'b0;
      prot_q <= '0;
    end else begin
      if (busy_done) wel <= 1'b0;
      if (cs_rise && !wip && bit_cnt == CNT_W'(8)) begin
        if (opcode == OP_SET_WEL) wel <= 1'b1;
        if (opcode == OP_CLR_WEL) wel <= 1'b0;
      end
      if (wr_start) prot_q <= data_byte & WR_MASK;
    end
  end

  assign status   = prot_q | {6'b0, wel, wip};
  assign rd_start = op_done && (opcode == OP_RD_STAT);

  sfsr_tx u_tx (
    .clk(clk), .rst(rst), .cs_idle(cs_s), .start(rd_start),
    .sck_fall(sck_fall), .status(status),
    .rd_active(rd_active), .miso_q(miso_q)
  );

  assign miso = rd_active ? miso_q : 1'bz;
endmodule

// File: rtl/sfsr_chk.sv
module sfsr_chk #(
  parameter int TW_CYCLES = 1000,
  localparam int TW_W = $clog2(TW_CYCLES + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            wip,
  input logic            wel,
  input logic [7:0]      prot_q,
  input logic            wp_s,
  input logic            cs_s,
  input logic            rd_active,
  input logic [TW_W-1:0] busy_cnt
);
  assert_wel_drop_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);

  assert_write_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_q) |-> $past(wel));

  assert_write_starts_busy_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(prot_q) |-> (wip && !$past(wip)));

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (prot_q[7] && !wp_s) |=> $stable(prot_q));

  assert_wel_frozen_busy_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(wip) && wip) |-> $stable(wel));

  assert_timer_bound_R7: assert property (@(posedge clk) disable iff (rst)
    busy_cnt < TW_W'(TW_CYCLES));

  assert_read_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !rd_active);
endmodule

bind spi_flash_sr sfsr_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wip(wip), .wel(wel), .prot_q(prot_q),
  .wp_s(wp_s), .cs_s(cs_s), .rd_active(rd_active), .busy_cnt(busy_cnt)
);

// File: tb/spi_flash_sr_bench.sv
module spi_flash_sr_bench;
  localparam int TW   = 1500;
  localparam int HALF = 8;
  localparam int GAP  = 8;

  logic clk = 0, rst = 1, cs_n = 1, sck = 0, mosi = 0, wp_n = 1;
  wire  miso;
  int   cyc = 0, checks = 0, fails = 0, cs_hi = 0;
  bit   done = 0;

  // reference model state
  logic [7:0] m_prot = 8'h00;
  logic       m_wel = 0, m_pend = 0;
  int         busy_until = 0;

  always #2.5 clk = ~clk;

  spi_flash_sr #(.TW_CYCLES(TW)) u_spi_flash_sr (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison: output must float when chip select is idle (R1, R3)
  always @(negedge clk) begin
    if (rst || !cs_n) cs_hi <= 0;
    else cs_hi <= cs_hi + 1;
    if (!rst && cs_n && cs_hi >= 4 && !done) begin
      checks++;
      if (miso !== 1'bz) begin
        fails++;
        $display("FAIL R3: miso got %b expected z while idle", miso);
      end
    end
  end

  function automatic logic [7:0] exp_status(input int t);
    logic w;
    w = (m_pend && t >= busy_until) ? 1'b0 : m_wel;
    return m_prot | {6'b0, w, (t < busy_until)};
  endfunction

  task automatic model_update(input int nbits, input logic [31:0] tx);
    logic [7:0] op;
    bit busy;
    op = tx[31:24];
    if (m_pend && cyc >= busy_until) begin m_wel = 0; m_pend = 0; end
    busy = cyc < busy_until;
    if (!busy) begin
      if (nbits == 8 && op == 8'h06) m_wel = 1;
      if (nbits == 8 && op == 8'h04) m_wel = 0;
      if (nbits == 16 && op == 8'h01 && m_wel && !(m_prot[7] && !wp_n)) begin
        m_prot = tx[23:16] & 8'h9C;
        busy_until = cyc + 3 + TW;
        m_pend = 1;
      end
    end
  endtask

  task automatic frame(input int nbits, input logic [31:0] tx,
                       output logic [31:0] rx, output int t8);
    rx = '0; t8 = cyc;
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[31-i];
      repeat (HALF) @(negedge clk);
      sck = 1; rx[31-i] = miso;
      if (i == 7) t8 = cyc;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    model_update(nbits, tx);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic cmd(input int nbits, input logic [7:0] op, input logic [7:0] d);
    logic [31:0] rx; int t8;
    frame(nbits, {op, d, 16'h0}, rx, t8);
  endtask

  task automatic read_stat(input string req, input int nbytes);
    logic [31:0] rx; int t8;
    logic [7:0] e;
    frame(8 + 8 * nbytes, {8'h05, 24'h0}, rx, t8);
    e = exp_status(t8 + HALF + 4);
    check(req, rx[23:16], e);
    if (nbytes > 1) check(req, rx[15:8], e);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (10) @(negedge clk);
    read_stat("R1 reset status", 1);

    cmd(16, 8'h01, 8'h9C);              read_stat("R4 write without latch", 1);
    cmd(9, 8'h06, 8'h00);               read_stat("R2 set latch 9 bits", 1);
    cmd(8, 8'h06, 8'h00);               read_stat("R2 set latch", 1);
    cmd(7, 8'h04, 8'h00);               read_stat("R2 clear latch 7 bits", 1);
    cmd(8, 8'h04, 8'h00);               read_stat("R2 clear latch", 1);
    cmd(8, 8'h06, 8'h00);
    cmd(15, 8'h01, 8'hFF);              read_stat("R5 write 15 bits", 1);
    cmd(17, 8'h01, 8'hFF);              read_stat("R5 write 17 bits", 1);
    read_stat("R3 repeated read", 2);

    cmd(16, 8'h01, 8'hFF);              read_stat("R7 busy during cycle", 1);
    cmd(8, 8'h04, 8'h00);               read_stat("R10 clear latch while busy", 1);
    cmd(16, 8'h01, 8'h00);              read_stat("R10 write while busy", 1);
    repeat (TW) @(negedge clk);         read_stat("R8 latch cleared after cycle", 1);

    wp_n = 0; repeat (10) @(negedge clk);
    cmd(8, 8'h06, 8'h00);               read_stat("R9 latch set while locked", 1);
    cmd(16, 8'h01, 8'h00);              read_stat("R9 write ignored while locked", 1);
    wp_n = 1; repeat (10) @(negedge clk);
    cmd(16, 8'h01, 8'h6B);
    repeat (TW + 100) @(negedge clk);   read_stat("R9 write accepted with pin high", 1);
    read_stat("R6 masked bits", 1);

    cmd(8, 8'h06, 8'h00);
    cmd(16, 8'h01, 8'h63);
    repeat (TW + 100) @(negedge clk);   read_stat("R6 reserved bits ignored", 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule